// File: doc/BRIEF.md
# Load Dependency Tracker

This block observes the stream of retired memory and non-memory instructions. It reports each case in which one load used, as its base address, a value that an earlier load produced. Every architectural register carries a producer tag. The tag holds the instruction address of the load that last wrote the register, or it is marked empty. When a load retires, the tag of its base register is read. If that tag is valid, the block emits a record naming the producer load, the consuming load and the consumer's immediate offset. Chains of such records describe pointer-chasing traversals such as linked lists: the link field, the key field and a name field each show up as a distinct offset from the same producer.

Pointers saved to memory and later restored would break the register chain. A small fully associative spill table covers that case. A store of a tagged register records the tag under the store's word address. A later load from that word restores the original producer tag into its destination register instead of its own address. Records leave through a single output register with a valid/ready handshake. While a record waits, the input side is held off.

Top module: `lddep_tracker`

## Requirements
- R1: After reset no record is pending, `in_ready` is high, and every register tag is empty, so a load retired first never emits a record.
- R2: A retired load (`in_kind` = 1) whose base register has a valid tag emits, one cycle later, a record with producer = that tag, consumer = the load's `in_pc` and offset = its `in_off`. Only loads emit records.
- R3: A load writes its own `in_pc` as the tag of its destination register. When the base and destination registers are the same, the record uses the tag held before this load.
- R4: A load whose base register tag is empty emits no record.
- R5: Register 0 is never tagged. A load with destination 0 leaves no tag, and a load with base 0 never emits a record.
- R6: A non-memory instruction (`in_kind` = 0) with a nonzero destination clears that register's tag.
- R7: A store (`in_kind` = 2) whose data register (`in_dreg`) has a valid tag files that tag under the store's word address. A later load from that word sets its destination tag to the filed tag, not to its own address.
- R8: A store whose data register has no valid tag drops any filed entry for that word. A later load from that word then tags its destination with its own address.
- R9: The spill table holds `SPILL_N` (default 8) entries and allocates new words in round-robin order. With the default size, the ninth distinct word stored after reset replaces the first.
- R10: While `dep_valid` is high and `dep_ready` is low, the record stays unchanged and `in_ready` is low. When the record is taken, a waiting input is accepted in the same cycle.
- R11: Spill matching uses word addresses (4-byte words by default). A load at a byte offset inside a filed word still matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Retired instruction present |
| in_ready | output | 1 | Tracker can accept an instruction |
| in_kind | input | 2 | 0 other, 1 load, 2 store, 3 ignored |
| in_pc | input | PCW | Instruction address |
| in_dreg | input | log2(NREG) | Destination register, or data register for a store |
| in_base | input | log2(NREG) | Base address register |
| in_off | input | OW | Immediate offset |
| in_ea | input | AW | Effective data address |
| dep_valid | output | 1 | Dependency record present |
| dep_ready | input | 1 | Consumer takes the record |
| dep_producer | output | PCW | Address of the producing load |
| dep_consumer | output | PCW | Address of the consuming load |
| dep_offset | output | OW | Consumer's immediate offset |

## Verification
A register tag that is wrongly set, stale or cleared shows up at the very next load that uses that register as its base. One cycle after that load, a record either appears or is missing, or it names the wrong producer. Corruption in the spill table stays hidden until a restore load and a second dependent load follow it. That takes at least two retired loads before a wrong producer address appears at the output. A faulty round-robin pointer shows only once more distinct words have been stored than the table holds.

// File: rtl/lddep_pkg.sv
package lddep_pkg;
   typedef enum logic [1:0] {
      K_OTHER = 2'd0,
      K_LOAD  = 2'd1,
      K_STORE = 2'd2,
      K_RSVD  = 2'd3
   } lddep_kind_e;
endpackage

// File: rtl/lddep_regtags.sv
module lddep_regtags #(
   parameter int NREG = 32,
   parameter int TW   = 32,
   localparam int IW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] ra_idx,
   output logic          ra_vld,
   output logic [TW-1:0] ra_tag,
   input  logic [IW-1:0] rb_idx,
   output logic          rb_vld,
   output logic [TW-1:0] rb_tag,
   input  logic          w_en,
   input  logic [IW-1:0] w_idx,
   input  logic          w_set,
   input  logic [TW-1:0] w_tag
);
   logic [NREG-1:0] tag_vld;
   logic [TW-1:0]   tag_mem [NREG];
   logic            w_ok;

   initial begin : elab_chk
      if (NREG < 2 || (1 << IW) != NREG) $fatal(1, "NREG must be a power of two >= 2");
   end

   assign w_ok = w_en && (w_idx != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) tag_vld <= '0;
      else if (w_ok) tag_vld[w_idx] <= w_set;
   end

   always_ff @(posedge clk) begin
      if (w_ok) tag_mem[w_idx] <= w_tag;
   end

   // Reads see the state before this cycle's write (read-before-write).
   assign ra_vld = tag_vld[ra_idx];
   assign ra_tag = tag_mem[ra_idx];
   assign rb_vld = tag_vld[rb_idx];
   assign rb_tag = tag_mem[rb_idx];
endmodule

// File: rtl/lddep_spill.sv
module lddep_spill #(
   parameter int N   = 8,
   parameter int AW  = 32,
   parameter int TW  = 32,
   parameter int WSH = 2,
   localparam int WA = AW - WSH,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] l_addr,
   output logic          l_hit,
   output logic [TW-1:0] l_tag,
   input  logic          st_en,
   input  logic [AW-1:0] st_addr,
   input  logic          st_set,
   input  logic [TW-1:0] st_tag
);
   logic [N-1:0]  e_vld;
   logic [WA-1:0] e_addr [N];
   logic [TW-1:0] e_tag  [N];
   logic [N-1:0]  lmatch, smatch;
   logic [PW-1:0] ptr;
   logic [WA-1:0] l_w, s_w;
   logic          s_any;
   logic          unused_lo;

   initial begin : elab_chk
      if (N < 1)    $fatal(1, "spill table needs at least one entry");
      if (WSH < 1)  $fatal(1, "word must span at least two bytes");
   end

   assign l_w       = l_addr[AW-1:WSH];
   assign s_w       = st_addr[AW-1:WSH];
   assign unused_lo = ^{l_addr[WSH-1:0], st_addr[WSH-1:0]};

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign lmatch[i] = e_vld[i] && (e_addr[i] == l_w);
      assign smatch[i] = e_vld[i] && (e_addr[i] == s_w);
   end

   assign l_hit = |lmatch;
   assign s_any = |smatch;

   always_comb begin
      l_tag = '0;
      for (int i = 0; i < N; i++) begin
         if (lmatch[i]) l_tag = l_tag | e_tag[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_vld <= '0;
         ptr   <= '0;
      end else if (st_en) begin
         if (s_any) begin
            for (int i = 0; i < N; i++) begin
               if (smatch[i]) e_vld[i] <= st_set;
            end
         end else if (st_set) begin
            e_vld[ptr] <= 1'b1;
            ptr        <= (ptr == PW'(N - 1)) ? '0 : ptr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (st_en) begin
         if (s_any) begin
            for (int i = 0; i < N; i++) begin
               if (smatch[i]) e_tag[i] <= st_tag;
            end
         end else if (st_set) begin
            e_addr[ptr] <= s_w;
            e_tag[ptr]  <= st_tag;
         end
      end
   end
endmodule

// File: rtl/lddep_outreg.sv
module lddep_outreg #(
   parameter int PCW = 32,
   parameter int OW  = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic [PCW-1:0] p_prod,
   input  logic [PCW-1:0] p_cons,
   input  logic [OW-1:0]  p_off,
   output logic           can_accept,
   output logic           o_valid,
   input  logic           o_ready,
   output logic [PCW-1:0] o_prod,
   output logic [PCW-1:0] o_cons,
   output logic [OW-1:0]  o_off
);
   assign can_accept = !o_valid || o_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)       o_valid <= 1'b0;
      else if (push)    o_valid <= 1'b1;
      else if (o_ready) o_valid <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (push) begin
         o_prod <= p_prod;
         o_cons <= p_cons;
         o_off  <= p_off;
      end
   end
endmodule

// File: rtl/lddep_tracker.sv
module lddep_tracker #(
   parameter int PCW        = 32,
   parameter int AW         = 32,
   parameter int OW         = 16,
   parameter int NREG       = 32,
   parameter int SPILL_N    = 8,
   parameter int WORD_BYTES = 4,
   parameter bit SPILL_EN   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [1:0]              in_kind,
   input  logic [PCW-1:0]          in_pc,
   input  logic [$clog2(NREG)-1:0] in_dreg,
   input  logic [$clog2(NREG)-1:0] in_base,
   input  logic [OW-1:0]           in_off,
   input  logic [AW-1:0]           in_ea,
   output logic                    dep_valid,
   input  logic                    dep_ready,
   output logic [PCW-1:0]          dep_producer,
   output logic [PCW-1:0]          dep_consumer,
   output logic [OW-1:0]           dep_offset
);
   import lddep_pkg::*;

   localparam int IW  = $clog2(NREG);
   localparam int WSH = $clog2(WORD_BYTES);

   initial begin : elab_chk
      if ((1 << WSH) != WORD_BYTES) $fatal(1, "WORD_BYTES must be a power of two");
   end

   lddep_kind_e    kind;
   logic           fire, is_ld, is_st, is_ot;
   logic           ra_vld, rb_vld;
   logic [PCW-1:0] ra_tag, rb_tag;
   logic           sp_hit;
   logic [PCW-1:0] sp_tag;
   logic           w_en;
   logic [PCW-1:0] w_tag;

   assign kind  = lddep_kind_e'(in_kind);
   assign fire  = in_valid && in_ready;
   assign is_ld = fire && (kind == K_LOAD);
   assign is_st = fire && (kind == K_STORE);
   assign is_ot = fire && (kind == K_OTHER);

   lddep_regtags #(.NREG(NREG), .TW(PCW)) i_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (in_base),
      .ra_vld (ra_vld),
      .ra_tag (ra_tag),
      .rb_idx (in_dreg),
      .rb_vld (rb_vld),
      .rb_tag (rb_tag),
      .w_en   (w_en),
      .w_idx  (in_dreg),
      .w_set  (is_ld),
      .w_tag  (w_tag)
   );

   generate
      if (SPILL_EN) begin : g_spill
         lddep_spill #(.N(SPILL_N), .AW(AW), .TW(PCW), .WSH(WSH)) i_spill (
            .clk     (clk),
            .rst_n   (rst_n),
            .l_addr  (in_ea),
            .l_hit   (sp_hit),
            .l_tag   (sp_tag),
            .st_en   (is_st),
            .st_addr (in_ea),
            .st_set  (rb_vld),
            .st_tag  (rb_tag)
         );
      end else begin : g_nospill
         logic unused_sp;
         assign unused_sp = ^{in_ea, is_st, rb_vld, rb_tag};
         assign sp_hit    = 1'b0;
         assign sp_tag    = '0;
      end
   endgenerate

   assign w_en  = (is_ld || is_ot) && (in_dreg != '0);
   assign w_tag = sp_hit ? sp_tag : in_pc;

   lddep_outreg #(.PCW(PCW), .OW(OW)) i_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (is_ld && ra_vld),
      .p_prod     (ra_tag),
      .p_cons     (in_pc),
      .p_off      (in_off),
      .can_accept (in_ready),
      .o_valid    (dep_valid),
      .o_ready    (dep_ready),
      .o_prod     (dep_producer),
      .o_cons     (dep_consumer),
      .o_off      (dep_offset)
   );
endmodule

// File: rtl/lddep_checker.sv
module lddep_checker #(
   parameter int PCW  = 32,
   parameter int OW   = 16,
   parameter int NREG = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic [1:0]              in_kind,
   input logic [PCW-1:0]          in_pc,
   input logic [$clog2(NREG)-1:0] in_base,
   input logic [OW-1:0]           in_off,
   input logic                    dep_valid,
   input logic                    dep_ready,
   input logic [PCW-1:0]          dep_producer,
   input logic [PCW-1:0]          dep_consumer,
   input logic [OW-1:0]           dep_offset
);
   logic fire_ld;
   assign fire_ld = in_valid && in_ready && (in_kind == lddep_pkg::K_LOAD);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dep_valid && !dep_ready |=> dep_valid && $stable(dep_producer)
                                  && $stable(dep_consumer) && $stable(dep_offset));

   p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dep_valid && !dep_ready |-> !in_ready);

   p_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dep_valid) |-> $past(fire_ld) && dep_consumer == $past(in_pc)
                           && dep_offset == $past(in_off));

   p_nonload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !fire_ld |=> !dep_valid);

   p_base0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire_ld && in_base == '0 |=> !dep_valid);
endmodule

bind lddep_tracker lddep_checker #(.PCW(PCW), .OW(OW), .NREG(NREG)) i_chk (.*);

// File: tb/test_lddep_tracker.sv
`timescale 1ns/100ps
module test_lddep_tracker;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [1:0]  in_kind;
   logic [31:0] in_pc;
   logic [4:0]  in_dreg;
   logic [4:0]  in_base;
   logic [15:0] in_off;
   logic [31:0] in_ea;
   logic        dep_valid;
   logic        dep_ready;
   logic [31:0] dep_producer;
   logic [31:0] dep_consumer;
   logic [15:0] dep_offset;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   localparam logic [1:0] OT = 2'd0, LD = 2'd1, ST = 2'd2;

   always #2.5 clk = ~clk;

   lddep_tracker i_lddep_tracker (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_dep(input string req, input bit ev, input logic [31:0] ep,
                            input logic [31:0] ec, input logic [15:0] eo);
      check({req, " valid"}, 64'(dep_valid), 64'(ev));
      if (ev) begin
         check({req, " producer"}, 64'(dep_producer), 64'(ep));
         check({req, " consumer"}, 64'(dep_consumer), 64'(ec));
         check({req, " offset"},   64'(dep_offset),   64'(eo));
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; dep_ready = 1'b1;
      in_kind = OT; in_pc = '0; in_dreg = '0; in_base = '0; in_off = '0; in_ea = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   // Drives one instruction for one edge; returns 1 ns after that edge.
   task automatic issue(input logic [1:0] k, input logic [31:0] pc, input int dr,
                        input int br, input logic [15:0] off, input logic [31:0] ea);
      in_valid = 1'b1; in_kind = k; in_pc = pc; in_dreg = dr[4:0];
      in_base = br[4:0]; in_off = off; in_ea = ea;
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 dep_valid after reset", 64'(dep_valid), 64'd0);
      check("R1 in_ready after reset",  64'(in_ready),  64'd1);
      issue(LD, 32'h100, 10, 16, 16'd0, 32'h1000);
      check_dep("R1 first load", 1'b0, '0, '0, '0);
   endtask

   task automatic t_list();
      do_reset();
      issue(LD, 32'h100, 10, 16, 16'd0, 32'h1000); check_dep("R4 key untagged", 1'b0, '0, '0, '0);
      issue(LD, 32'h104, 4, 16, 16'd4, 32'h1004);  check_dep("R4 name untagged", 1'b0, '0, '0, '0);
      issue(LD, 32'h118, 16, 16, 16'd8, 32'h1008); check_dep("R4 link untagged", 1'b0, '0, '0, '0);
      for (int it = 0; it < 2; it++) begin
         issue(LD, 32'h100, 10, 16, 16'd0, 32'h2500);
         check_dep("R2 key field", 1'b1, 32'h118, 32'h100, 16'd0);
         issue(LD, 32'h104, 4, 16, 16'd4, 32'h2504);
         check_dep("R2 name field", 1'b1, 32'h118, 32'h104, 16'd4);
         issue(LD, 32'h118, 16, 16, 16'd8, 32'h2508);
         check_dep("R3 link self dependency", 1'b1, 32'h118, 32'h118, 16'd8);
      end
      issue(LD, 32'h12c, 2, 4, 16'd0, 32'h3000);
      check_dep("R3 dest tag of name load", 1'b1, 32'h104, 32'h12c, 16'd0);
   endtask

   task automatic t_clear_and_r0();
      do_reset();
      issue(LD, 32'h118, 16, 16, 16'd8, 32'h1008);
      issue(OT, 32'h200, 16, 0, 16'd0, 32'h0);
      check_dep("R2 other emits nothing", 1'b0, '0, '0, '0);
      issue(LD, 32'h100, 10, 16, 16'd0, 32'h1000);
      check_dep("R6 cleared tag", 1'b0, '0, '0, '0);
      issue(LD, 32'h300, 0, 16, 16'd0, 32'h1000);
      issue(LD, 32'h304, 11, 0, 16'd0, 32'h0);
      check_dep("R5 base r0", 1'b0, '0, '0, '0);
   endtask

   task automatic t_spill();
      do_reset();
      issue(LD, 32'h118, 16, 16, 16'd8, 32'h1008);
      issue(ST, 32'h140, 16, 29, 16'd0, 32'h8000);
      check_dep("R2 store emits nothing", 1'b0, '0, '0, '0);
      issue(OT, 32'h144, 16, 0, 16'd0, 32'h0);
      issue(LD, 32'h148, 16, 29, 16'd2, 32'h8002);
      check_dep("R7 restore untagged base", 1'b0, '0, '0, '0);
      issue(LD, 32'h100, 10, 16, 16'd0, 32'h1000);
      check_dep("R7 R11 restored producer", 1'b1, 32'h118, 32'h100, 16'd0);
      issue(ST, 32'h150, 5, 29, 16'd0, 32'h8000);
      issue(LD, 32'h154, 16, 29, 16'd0, 32'h8000);
      issue(LD, 32'h100, 10, 16, 16'd0, 32'h1000);
      check_dep("R8 dropped entry", 1'b1, 32'h154, 32'h100, 16'd0);
   endtask

   task automatic t_evict();
      do_reset();
      issue(LD, 32'h118, 16, 16, 16'd8, 32'h1008);
      for (int i = 0; i < 9; i++) issue(ST, 32'h400 + 32'(i), 16, 29, 16'd0, 32'h9000 + 32'(4*i));
      issue(LD, 32'h160, 20, 29, 16'd0, 32'h9000);
      issue(LD, 32'h164, 21, 20, 16'd0, 32'h0);
      check_dep("R9 oldest evicted", 1'b1, 32'h160, 32'h164, 16'd0);
      issue(LD, 32'h168, 22, 29, 16'd0, 32'h9004);
      issue(LD, 32'h16c, 23, 22, 16'd0, 32'h0);
      check_dep("R9 second entry kept", 1'b1, 32'h118, 32'h16c, 16'd0);
      issue(LD, 32'h170, 24, 29, 16'd0, 32'h9020);
      issue(LD, 32'h174, 25, 24, 16'd0, 32'h0);
      check_dep("R9 ninth word filed", 1'b1, 32'h118, 32'h174, 16'd0);
   endtask

   task automatic t_stall();
      do_reset();
      issue(LD, 32'h118, 16, 16, 16'd8, 32'h1008);
      dep_ready = 1'b0;
      issue(LD, 32'h100, 10, 16, 16'd0, 32'h1000);
      check_dep("R10 record pending", 1'b1, 32'h118, 32'h100, 16'd0);
      check("R10 in_ready low", 64'(in_ready), 64'd0);
      in_valid = 1'b1; in_kind = LD; in_pc = 32'h104; in_dreg = 5'd4;
      in_base = 5'd16; in_off = 16'd4; in_ea = 32'h1004;
      repeat (2) begin
         @(posedge clk); #1;
         check_dep("R10 record held", 1'b1, 32'h118, 32'h100, 16'd0);
      end
      dep_ready = 1'b1;
      @(posedge clk); #1;
      in_valid = 1'b0;
      check_dep("R10 waiting input taken", 1'b1, 32'h118, 32'h104, 16'd4);
      @(posedge clk); #1;
      check_dep("R10 no duplicate", 1'b0, '0, '0, '0);
   endtask

   initial begin
      t_reset();
      t_list();
      t_clear_and_r0();
      t_spill();
      t_evict();
      t_stall();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule